// File: doc/BRIEF.md
# Indirect-Register Interrupt Redirection Controller

This block routes up to a parameterised number of interrupt input pins to a downstream delivery port. Each pin owns a 64-bit redirection entry. The entry sets the vector, the delivery mode, the destination and its mode, the trigger type and a mask. The controller keeps a request bit per pin. Level pins also carry a remote-pending bit that stays set from a successful delivery until an end-of-interrupt (EOI) names the pin's vector. Software reaches all internal state indirectly: it writes an index into a select register and then reads or writes a 32-bit data window.

Assertion and deassertion events come in on a strobe that carries a pin number and a level. EOI broadcasts come in with a vector. Pending pins are offered one at a time on a request/accept handshake. The receiver answers with the number of targets that took the interrupt.

A level interrupt that is never serviced can cause an EOI storm. To stop that storm from locking up the block, immediate redelivery is suppressed once a pin's run of successive EOI redeliveries reaches a limit. A single delayed rescan then services the level pins that are still pending.

Top module: `irq_redirect_ctrl`

## Requirements
- R1: Bus offset 0x00 is the select register: a write keeps only the low 8 bits, and a read returns them zero-extended. Bus offset 0x10 is the data window for the selected index. Reads at any other offset return zero.
- R2: Index 0x00 holds a 4-bit identifier in window bits 27:24, and the other window bits read as zero. Index 0x02 reads the same value, and writes to index 0x02 change nothing.
- R3: Index 0x01 is read-only and returns (NUM_PINS-1) in bits 23:16 and 0x11 in bits 7:0.
- R4: An index of 0x10 or above selects entry (index-0x10)>>1. An odd index reaches bits 63:32 and an even index reaches bits 31:0. Entry fields: vector 7:0, delivery mode 10:8, destination mode 11, remote-pending 14 (read-only), trigger 15 (1 = level), mask 16 (1 = masked), destination 63:56. Indices 0x03 to 0x0F and entries at or above NUM_PINS read all ones, and writes to them are dropped.
- R5: After reset the select register and the identifier are zero, every entry reads 0x00010000 (masked) in its lower half and zero in its upper half, and no delivery is requested.
- R6: Asserting an edge pin sets its request bit and offers it. Acceptance clears the request bit. Asserting an edge pin whose request bit is already set pulses the coalesced output one cycle later and offers nothing.
- R7: A masked pin is never offered, and its request bit stays pending.
- R8: A level delivery accepted with a nonzero count sets remote-pending. While remote-pending is set, the pin is not offered again, and further assertions of the pin are reported as coalesced.
- R9: Writing the lower half of an entry clears its remote-pending bit. If the written entry is level-triggered and its request bit is set, it is offered at once.
- R10: An EOI whose vector matches a level entry clears remote-pending. If that pin is unmasked and still requested, it is offered again. Otherwise the pin's run of successive EOIs is reset.
- R11: The STORM_LIMIT-th successive EOI redelivery of a pin is suppressed and its run counter restarts. RESCAN_DELAY cycles later, one rescan offers every unmasked, requested level pin that has remote-pending clear.
- R12: Among pending pins, the lowest-numbered one is offered first, one per handshake. The request and its fields hold stable until accepted. A level delivery accepted with count zero leaves remote-pending clear.
- R13: Deasserting a pin clears its request bit, so unmasking it afterwards offers nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Bus write strobe |
| busAddr | input | 8 | Byte offset within the register region |
| busWrData | input | 32 | Bus write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| lineStrobe | input | 1 | Pin event strobe |
| lineNum | input | PIN_W | Pin number of the event |
| lineLevel | input | 1 | 1 = assert, 0 = deassert |
| lineCoalesced | output | 1 | Pulses one cycle after an assertion that was coalesced |
| eoiValid | input | 1 | EOI broadcast strobe |
| eoiVector | input | 8 | Vector named by the EOI |
| dlvReq | output | 1 | Delivery offer valid |
| dlvPin | output | PIN_W | Pin being offered |
| dlvVector | output | 8 | Vector of the offered entry |
| dlvMode | output | 3 | Delivery mode of the offered entry |
| dlvDestMode | output | 1 | Destination mode of the offered entry |
| dlvLevel | output | 1 | Trigger type of the offered entry |
| dlvDest | output | 8 | Destination of the offered entry |
| dlvAccept | input | 1 | Receiver accepts the current offer |
| dlvCount | input | 8 | Number of targets that took the interrupt |

## Verification
The bench sweeps every select value against arithmetically computed window contents. A decoder that ignores the unsigned wrap below 0x10, or that swaps the odd and even halves, shows up as wrong read data at specific indices. It drives repeated assertions on masked edge pins and on level pins with remote-pending set, to catch designs that redeliver instead of coalescing. It also runs an EOI sequence up to the storm limit, to catch a design that redelivers on the limit EOI or never rescans. Finally, it holds an offer while lower and higher pins arrive, so that a wrong arbitration order or an offer that changes before acceptance is visible.

// File: rtl/irq_redirect_pkg.sv
package irq_redirect_pkg;

  localparam logic [7:0] OFS_SELECT   = 8'h00;
  localparam logic [7:0] OFS_WINDOW   = 8'h10;

  localparam logic [7:0] IDX_ID       = 8'h00;
  localparam logic [7:0] IDX_VERSION  = 8'h01;
  localparam logic [7:0] IDX_ARB      = 8'h02;
  localparam logic [7:0] IDX_TABLE    = 8'h10;

  localparam logic [7:0] VERSION_CODE = 8'h11;

  localparam int BIT_REMOTE = 14;
  localparam int BIT_TRIG   = 15;
  localparam int BIT_MASK   = 16;

  localparam logic [31:0] LO_RESET = 32'h0001_0000;

  // strobes from control to datapath
  typedef struct packed {
    logic       acceptValid;  // offer accepted this cycle
    logic       acceptHit;    // receiver reported a nonzero count
    logic [7:0] offerPin;     // pin currently offered
  } ctlStrobe_t;

endpackage

// File: rtl/irq_redirect_dp.sv
module irq_redirect_dp
  import irq_redirect_pkg::*;
#(
  parameter int NUM_PINS    = 24,
  parameter int STORM_LIMIT = 10000,
  parameter int PIN_W       = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [7:0]          busAddr,
  input  logic [31:0]         busWrData,
  output logic [31:0]         busRdData,
  input  logic                lineStrobe,
  input  logic [PIN_W-1:0]    lineNum,
  input  logic                lineLevel,
  output logic                lineCoalesced,
  input  logic                eoiValid,
  input  logic [7:0]          eoiVector,
  input  ctlStrobe_t          strb,
  output logic [NUM_PINS-1:0] maskVec,
  output logic [NUM_PINS-1:0] levelVec,
  output logic [NUM_PINS-1:0] irrVec,
  output logic [NUM_PINS-1:0] remoteVec,
  output logic [NUM_PINS-1:0] svcKick,
  output logic                stormHit,
  output logic [7:0]          dlvVector,
  output logic [2:0]          dlvMode,
  output logic                dlvDestMode,
  output logic                dlvLevel,
  output logic [7:0]          dlvDest
);

  localparam int CNT_W = $clog2(STORM_LIMIT + 1);

  logic [7:0]  selReg;
  logic [3:0]  idReg;
  logic        selWr, winWr;
  logic [6:0]  tblIdx;
  logic        tblInRange, hiHalf;
  logic [31:0] winData;
  logic [31:0] loRd [NUM_PINS];
  logic [31:0] hiRd [NUM_PINS];
  logic [NUM_PINS-1:0] coalVec, reachVec;

  assign selWr      = busWrEn && (busAddr == OFS_SELECT);
  assign winWr      = busWrEn && (busAddr == OFS_WINDOW);
  assign tblIdx     = 7'((selReg - IDX_TABLE) >> 1);
  assign tblInRange = (selReg >= IDX_TABLE) && ({1'b0, tblIdx} < 8'(NUM_PINS));
  assign hiHalf     = selReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg        <= '0;
      idReg         <= '0;
      lineCoalesced <= 1'b0;
    end else begin
      if (selWr) selReg <= busWrData[7:0];
      if (winWr && (selReg == IDX_ID)) idReg <= busWrData[27:24];
      lineCoalesced <= |coalVec;
    end
  end

  // window read decode; unsigned wrap below the table reads all ones
  always_comb begin
    winData = '1;
    if (selReg == IDX_ID || selReg == IDX_ARB)
      winData = {4'b0, idReg, 24'b0};
    else if (selReg == IDX_VERSION)
      winData = {8'b0, 8'(NUM_PINS - 1), 8'b0, VERSION_CODE};
    else if (tblInRange)
      winData = hiHalf ? hiRd[tblIdx[PIN_W-1:0]] : loRd[tblIdx[PIN_W-1:0]];
  end

  always_comb begin
    if (busAddr == OFS_SELECT)      busRdData = {24'b0, selReg};
    else if (busAddr == OFS_WINDOW) busRdData = winData;
    else                            busRdData = '0;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [31:0]      loReg, hiReg;
    logic             irrBit, remoteBit;
    logic [CNT_W-1:0] cnt;
    logic lineHit, wrLoHit, wrHiHit, isLevel, isMasked, eoiHit, accHit;
    logic eoiRetry, stormReach;

    assign lineHit    = lineStrobe && (lineNum == PIN_W'(i));
    assign wrLoHit    = winWr && tblInRange && !hiHalf && (tblIdx == 7'(i));
    assign wrHiHit    = winWr && tblInRange && hiHalf && (tblIdx == 7'(i));
    assign isLevel    = loReg[BIT_TRIG];
    assign isMasked   = loReg[BIT_MASK];
    assign eoiHit     = eoiValid && isLevel && (loReg[7:0] == eoiVector);
    assign accHit     = strb.acceptValid && (strb.offerPin == 8'(i));
    assign eoiRetry   = eoiHit && !isMasked && irrBit;
    assign stormReach = eoiRetry && (cnt == CNT_W'(STORM_LIMIT - 1));

    assign coalVec[i]  = lineHit && lineLevel && (isLevel ? remoteBit : irrBit);
    assign reachVec[i] = stormReach;
    assign svcKick[i]  = (lineHit && lineLevel && !coalVec[i])
                       || (wrLoHit && busWrData[BIT_TRIG] && irrBit)
                       || (eoiRetry && !stormReach);

    assign maskVec[i]   = isMasked;
    assign levelVec[i]  = isLevel;
    assign irrVec[i]    = irrBit;
    assign remoteVec[i] = remoteBit;
    assign loRd[i]      = loReg | {17'b0, remoteBit, 14'b0};
    assign hiRd[i]      = hiReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loReg     <= LO_RESET;
        hiReg     <= '0;
        irrBit    <= 1'b0;
        remoteBit <= 1'b0;
        cnt       <= '0;
      end else begin
        if (wrLoHit) loReg <= busWrData & ~(32'h1 << BIT_REMOTE);
        if (wrHiHit) hiReg <= busWrData;
        if (accHit && !isLevel) irrBit <= 1'b0;
        if (lineHit) irrBit <= lineLevel;
        if (accHit && isLevel && strb.acceptHit) remoteBit <= 1'b1;
        if (wrLoHit || eoiHit) remoteBit <= 1'b0;
        if (eoiHit) cnt <= (eoiRetry && !stormReach) ? cnt + 1'b1 : '0;
      end
    end

    // R6: edge acceptance drops the request bit
    a_r6_edge_accept_clears: assert property (@(posedge clk) disable iff (!rstN)
      accHit && !isLevel && !lineHit |=> !irrBit);
    // R8: accepted level delivery with targets sets remote-pending
    a_r8_level_sets_remote: assert property (@(posedge clk) disable iff (!rstN)
      accHit && isLevel && strb.acceptHit && !wrLoHit && !eoiHit |=> remoteBit);
    // R10: matching EOI clears remote-pending
    a_r10_eoi_clears_remote: assert property (@(posedge clk) disable iff (!rstN)
      eoiHit && !accHit |=> !remoteBit);
    // R11: run counter never reaches the limit
    a_r11_count_below_limit: assert property (@(posedge clk) disable iff (!rstN)
      eoiHit |=> cnt < CNT_W'(STORM_LIMIT));
  end

  assign stormHit = |reachVec;

  assign dlvVector   = loRd[strb.offerPin[PIN_W-1:0]][7:0];
  assign dlvMode     = loRd[strb.offerPin[PIN_W-1:0]][10:8];
  assign dlvDestMode = loRd[strb.offerPin[PIN_W-1:0]][11];
  assign dlvLevel    = loRd[strb.offerPin[PIN_W-1:0]][BIT_TRIG];
  assign dlvDest     = hiRd[strb.offerPin[PIN_W-1:0]][31:24];

endmodule

// File: rtl/irq_redirect_ctl.sv
module irq_redirect_ctl
  import irq_redirect_pkg::*;
#(
  parameter int NUM_PINS     = 24,
  parameter int RESCAN_DELAY = 1024,
  parameter int PIN_W        = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] maskVec,
  input  logic [NUM_PINS-1:0] levelVec,
  input  logic [NUM_PINS-1:0] irrVec,
  input  logic [NUM_PINS-1:0] remoteVec,
  input  logic [NUM_PINS-1:0] svcKick,
  input  logic                stormHit,
  input  logic                dlvAccept,
  input  logic [7:0]          dlvCount,
  output ctlStrobe_t          strb,
  output logic                dlvReq,
  output logic [PIN_W-1:0]    dlvPin
);

  localparam int TMR_W = $clog2(RESCAN_DELAY + 1);

  logic [NUM_PINS-1:0] svcReq, eligible, holdMask, rescanKick, lowMask;
  logic [NUM_PINS-1:0] maskPrev, eligPrev;
  logic                busyQ, pickFound, acceptNow, pendQ, timerDone;
  logic [PIN_W-1:0]    curPin, pickPin;
  logic [TMR_W-1:0]    timerQ;

  assign eligible  = svcReq & ~maskVec & irrVec & ~(levelVec & remoteVec);
  assign holdMask  = busyQ ? (NUM_PINS'(1) << curPin) : '0;
  assign lowMask   = (NUM_PINS'(1) << curPin) - NUM_PINS'(1);
  assign acceptNow = busyQ && dlvAccept;
  assign timerDone = pendQ && (timerQ == TMR_W'(RESCAN_DELAY - 1));
  assign rescanKick = timerDone ? (levelVec & irrVec & ~remoteVec & ~maskVec) : '0;

  // fixed priority: lowest pin number wins
  always_comb begin
    pickFound = 1'b0;
    pickPin   = '0;
    for (int k = NUM_PINS - 1; k >= 0; k--) begin
      if (eligible[k]) begin
        pickFound = 1'b1;
        pickPin   = PIN_W'(k);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      svcReq   <= '0;
      busyQ    <= 1'b0;
      curPin   <= '0;
      pendQ    <= 1'b0;
      timerQ   <= '0;
      maskPrev <= '0;
      eligPrev <= '0;
    end else begin
      svcReq   <= (svcReq & (eligible | holdMask) & ~(acceptNow ? holdMask : '0))
                | svcKick | rescanKick;
      maskPrev <= maskVec;
      eligPrev <= eligible;
      if (!busyQ && pickFound) begin
        busyQ  <= 1'b1;
        curPin <= pickPin;
      end else if (acceptNow) begin
        busyQ  <= 1'b0;
      end
      if (pendQ) begin
        if (timerDone) begin
          pendQ  <= 1'b0;
          timerQ <= '0;
        end else begin
          timerQ <= timerQ + 1'b1;
        end
      end else if (stormHit) begin
        pendQ  <= 1'b1;
      end
    end
  end

  assign strb.acceptValid = acceptNow;
  assign strb.acceptHit   = (dlvCount != 8'd0);
  assign strb.offerPin    = 8'(curPin);
  assign dlvReq           = busyQ;
  assign dlvPin           = curPin;

  // R12: offer held until accepted
  a_r12_offer_stable: assert property (@(posedge clk) disable iff (!rstN)
    dlvReq && !dlvAccept |=> dlvReq && $stable(dlvPin));
  // R12: new offer is the lowest eligible pin
  a_r12_lowest_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> eligPrev[curPin] && ((eligPrev & lowMask) == '0));
  // R7: a masked pin is never picked
  a_r7_masked_not_offered: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> !maskPrev[curPin]);
  // R11: rescan timer stays within its window
  a_r11_timer_window: assert property (@(posedge clk) disable iff (!rstN)
    pendQ |-> timerQ < TMR_W'(RESCAN_DELAY));

endmodule

// File: rtl/irq_redirect_ctrl.sv
module irq_redirect_ctrl
  import irq_redirect_pkg::*;
#(
  parameter int NUM_PINS     = 24,
  parameter int STORM_LIMIT  = 10000,
  parameter int RESCAN_DELAY = 1024,
  localparam int PIN_W       = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic [7:0]       busAddr,
  input  logic [31:0]      busWrData,
  output logic [31:0]      busRdData,
  input  logic             lineStrobe,
  input  logic [PIN_W-1:0] lineNum,
  input  logic             lineLevel,
  output logic             lineCoalesced,
  input  logic             eoiValid,
  input  logic [7:0]       eoiVector,
  output logic             dlvReq,
  output logic [PIN_W-1:0] dlvPin,
  output logic [7:0]       dlvVector,
  output logic [2:0]       dlvMode,
  output logic             dlvDestMode,
  output logic             dlvLevel,
  output logic [7:0]       dlvDest,
  input  logic             dlvAccept,
  input  logic [7:0]       dlvCount
);

  ctlStrobe_t          strb;
  logic [NUM_PINS-1:0] maskVec, levelVec, irrVec, remoteVec, svcKick;
  logic                stormHit;

  irq_redirect_dp #(
    .NUM_PINS(NUM_PINS), .STORM_LIMIT(STORM_LIMIT), .PIN_W(PIN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .lineStrobe(lineStrobe), .lineNum(lineNum), .lineLevel(lineLevel),
    .lineCoalesced(lineCoalesced),
    .eoiValid(eoiValid), .eoiVector(eoiVector),
    .strb(strb),
    .maskVec(maskVec), .levelVec(levelVec), .irrVec(irrVec), .remoteVec(remoteVec),
    .svcKick(svcKick), .stormHit(stormHit),
    .dlvVector(dlvVector), .dlvMode(dlvMode), .dlvDestMode(dlvDestMode),
    .dlvLevel(dlvLevel), .dlvDest(dlvDest)
  );

  irq_redirect_ctl #(
    .NUM_PINS(NUM_PINS), .RESCAN_DELAY(RESCAN_DELAY), .PIN_W(PIN_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN),
    .maskVec(maskVec), .levelVec(levelVec), .irrVec(irrVec), .remoteVec(remoteVec),
    .svcKick(svcKick), .stormHit(stormHit),
    .dlvAccept(dlvAccept), .dlvCount(dlvCount),
    .strb(strb), .dlvReq(dlvReq), .dlvPin(dlvPin)
  );

endmodule

// File: tb/irq_redirect_ctrl_bench.sv
module irq_redirect_ctrl_bench;

  localparam int NP = 8;
  localparam int PW = 3;
  localparam int LIM = 5;
  localparam int DLY = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWrEn = 1'b0;
  logic [7:0]    busAddr = '0;
  logic [31:0]   busWrData = '0;
  logic [31:0]   busRdData;
  logic          lineStrobe = 1'b0;
  logic [PW-1:0] lineNum = '0;
  logic          lineLevel = 1'b0;
  logic          lineCoalesced;
  logic          eoiValid = 1'b0;
  logic [7:0]    eoiVector = '0;
  logic          dlvReq;
  logic [PW-1:0] dlvPin;
  logic [7:0]    dlvVector;
  logic [2:0]    dlvMode;
  logic          dlvDestMode;
  logic          dlvLevel;
  logic [7:0]    dlvDest;
  logic          dlvAccept = 1'b0;
  logic [7:0]    dlvCount = '0;

  int  nChk = 0;
  int  nBad = 0;
  bit  done = 0;

  always #4 clk = ~clk;

  irq_redirect_ctrl #(.NUM_PINS(NP), .STORM_LIMIT(LIM), .RESCAN_DELAY(DLY)) u_irq_redirect_ctrl (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .lineStrobe(lineStrobe), .lineNum(lineNum), .lineLevel(lineLevel),
    .lineCoalesced(lineCoalesced),
    .eoiValid(eoiValid), .eoiVector(eoiVector),
    .dlvReq(dlvReq), .dlvPin(dlvPin), .dlvVector(dlvVector), .dlvMode(dlvMode),
    .dlvDestMode(dlvDestMode), .dlvLevel(dlvLevel), .dlvDest(dlvDest),
    .dlvAccept(dlvAccept), .dlvCount(dlvCount)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic regWr(logic [7:0] sel, logic [31:0] d);
    busWrite(8'h00, {24'b0, sel});
    busWrite(8'h10, d);
  endtask

  task automatic regRd(logic [7:0] sel, output logic [31:0] d);
    busWrite(8'h00, {24'b0, sel});
    busRead(8'h10, d);
  endtask

  task automatic lineEv(int pin, bit lvl, output bit coal);
    @(negedge clk);
    lineStrobe = 1'b1; lineNum = PW'(pin); lineLevel = lvl;
    @(negedge clk);
    lineStrobe = 1'b0;
    coal = lineCoalesced;
  endtask

  task automatic sendEoi(logic [7:0] v);
    @(negedge clk);
    eoiValid = 1'b1; eoiVector = v;
    @(negedge clk);
    eoiValid = 1'b0;
  endtask

  task automatic waitOffer(int maxCyc, output bit found);
    found = 0;
    for (int c = 0; c < maxCyc && !found; c++) begin
      @(negedge clk);
      if (dlvReq) found = 1;
    end
  endtask

  task automatic acceptNow(logic [7:0] cnt);
    dlvAccept = 1'b1; dlvCount = cnt;
    @(negedge clk);
    dlvAccept = 1'b0; dlvCount = '0;
  endtask

  task automatic expectOffer(string tag, int pin, logic [7:0] vec, logic [7:0] cnt);
    bit f;
    waitOffer(10, f);
    chk({tag, " offered"}, 32'(f), 32'd1);
    if (f) begin
      chk({tag, " pin"}, 32'(dlvPin), 32'(pin));
      chk({tag, " vector"}, 32'(dlvVector), 32'(vec));
      acceptNow(cnt);
    end
  endtask

  task automatic expectNone(string tag, int cycles);
    bit seen = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (dlvReq) seen = 1;
    end
    chk({tag, " no offer"}, 32'(seen), 32'd0);
  endtask

  function automatic logic [31:0] loPat(int p);
    return 32'h0001_4000 | (32'(p) << 20) | (32'h40 + 32'(p));
  endfunction

  function automatic logic [31:0] hiPat(int p);
    return 32'h5A00_0000 ^ (32'(p) * 32'h0101_0101);
  endfunction

  function automatic logic [31:0] expWin(int sel);
    int idx;
    if (sel == 0 || sel == 2) return 32'h0F00_0000;
    if (sel == 1) return 32'h0007_0011;
    if (sel < 16) return 32'hFFFF_FFFF;
    idx = (sel - 16) >> 1;
    if (idx >= NP) return 32'hFFFF_FFFF;
    if (sel % 2 == 1) return hiPat(idx);
    return loPat(idx) & ~32'h4000;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChk++; nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit c;
    bit f;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R5: reset state
    busRead(8'h00, d); chk("R5 select", d, 32'h0);
    regRd(8'h00, d); chk("R5 id", d, 32'h0);
    for (int p = 0; p < NP; p++) begin
      regRd(8'(16 + 2 * p), d); chk("R5 entry lo", d, 32'h0001_0000);
      regRd(8'(17 + 2 * p), d); chk("R5 entry hi", d, 32'h0);
    end
    chk("R5 no request", 32'(dlvReq), 32'd0);

    // R1: select keeps 8 bits, other offsets read zero
    busWrite(8'h00, 32'h0000_01A5);
    busRead(8'h00, d); chk("R1 select 8 bits", d, 32'h0000_00A5);
    busRead(8'h20, d); chk("R1 other offset", d, 32'h0);
    busRead(8'h04, d); chk("R1 unaligned offset", d, 32'h0);

    // R2, R3: identifier, arbitration and version
    regWr(8'h00, 32'hFFFF_FFFF);
    regRd(8'h00, d); chk("R2 id bits", d, 32'h0F00_0000);
    regWr(8'h02, 32'h0);
    regRd(8'h02, d); chk("R2 arb reads id", d, 32'h0F00_0000);
    regRd(8'h00, d); chk("R2 arb write ignored", d, 32'h0F00_0000);
    regWr(8'h01, 32'h0);
    regRd(8'h01, d); chk("R3 version", d, 32'h0007_0011);

    // R4: fill table, poke unmapped indices, sweep every select value
    for (int p = 0; p < NP; p++) begin
      regWr(8'(16 + 2 * p), loPat(p));
      regWr(8'(17 + 2 * p), hiPat(p));
    end
    regWr(8'h20, 32'h0);
    regWr(8'h21, 32'h0);
    regWr(8'h05, 32'h0);
    for (int s = 0; s < 256; s++) begin
      regRd(8'(s), d); chk("R4 window sweep", d, expWin(s));
    end
    chk("R4 masked table idle", 32'(dlvReq), 32'd0);

    // R6: edge pin 2, vector 0x31, destination 7
    regWr(8'h15, 32'h0700_0000);
    regWr(8'h14, 32'h0000_0031);
    lineEv(2, 1, c); chk("R6 first assert coalesced", 32'(c), 32'd0);
    waitOffer(10, f); chk("R6 offered", 32'(f), 32'd1);
    chk("R6 pin", 32'(dlvPin), 32'd2);
    chk("R6 dest", 32'(dlvDest), 32'h07);
    chk("R6 trigger", 32'(dlvLevel), 32'd0);
    if (f) acceptNow(8'd1);
    lineEv(2, 0, c);
    lineEv(2, 1, c); chk("R6 reassert after accept", 32'(c), 32'd0);
    expectOffer("R6 second edge", 2, 8'h31, 8'd1);
    lineEv(2, 0, c);
    // R7: masked edge stays pending, second assert coalesces
    regWr(8'h14, 32'h0001_0031);
    lineEv(2, 1, c); chk("R7 masked assert", 32'(c), 32'd0);
    expectNone("R7 masked edge", 8);
    lineEv(2, 1, c); chk("R6 coalesced pulse", 32'(c), 32'd1);
    expectNone("R6 coalesced", 8);

    // R7, R9: masked level pin 5 unmasked by lower write
    regWr(8'h1A, 32'h0001_8055);
    lineEv(5, 1, c);
    expectNone("R7 masked level", 8);
    regWr(8'h1A, 32'h0000_8055);
    expectOffer("R9 unmask level", 5, 8'h55, 8'd1);
    expectNone("R8 remote blocks", 8);
    lineEv(5, 1, c); chk("R8 assert with remote", 32'(c), 32'd1);
    regRd(8'h1A, d); chk("R8 remote visible", d, 32'h0000_C055);
    // R10: EOI redelivers while requested
    sendEoi(8'h55);
    expectOffer("R10 eoi redeliver", 5, 8'h55, 8'd1);
    lineEv(5, 0, c);
    sendEoi(8'h55);
    expectNone("R10 eoi after deassert", 8);
    regRd(8'h1A, d); chk("R10 remote cleared", d, 32'h0000_8055);
    // R13: deassert drops a masked request
    regWr(8'h1A, 32'h0001_8055);
    lineEv(5, 1, c);
    lineEv(5, 0, c);
    regWr(8'h1A, 32'h0000_8055);
    expectNone("R13 deasserted", 8);
    // R12: zero count leaves remote clear
    lineEv(5, 1, c);
    expectOffer("R12 zero count", 5, 8'h55, 8'd0);
    regRd(8'h1A, d); chk("R12 remote stays clear", d, 32'h0000_8055);
    // R9: lower write with remote set redelivers at once
    sendEoi(8'h55);
    expectOffer("R9 pre", 5, 8'h55, 8'd1);
    regWr(8'h1A, 32'h0000_8055);
    expectOffer("R9 lower write", 5, 8'h55, 8'd1);
    lineEv(5, 0, c);
    sendEoi(8'h55);
    expectNone("R9 cleanup", 4);

    // R11: storm on level pin 3
    regWr(8'h16, 32'h0000_8063);
    lineEv(3, 1, c);
    expectOffer("R11 first", 3, 8'h63, 8'd1);
    for (int k = 1; k < LIM; k++) begin
      sendEoi(8'h63);
      expectOffer("R11 eoi run", 3, 8'h63, 8'd1);
    end
    sendEoi(8'h63);
    expectNone("R11 suppressed", 12);
    waitOffer(30, f); chk("R11 rescan offered", 32'(f), 32'd1);
    chk("R11 rescan pin", 32'(dlvPin), 32'd3);
    if (f) acceptNow(8'd1);
    sendEoi(8'h63);
    expectOffer("R11 run restarted", 3, 8'h63, 8'd1);
    lineEv(3, 0, c);
    sendEoi(8'h63);
    expectNone("R11 cleanup", 4);

    // R12: priority and hold
    regWr(8'h12, 32'h0000_0081);
    regWr(8'h18, 32'h0000_0084);
    regWr(8'h1C, 32'h0000_0086);
    lineEv(6, 1, c);
    waitOffer(10, f); chk("R12 first offer", 32'(f), 32'd1);
    lineEv(4, 1, c);
    lineEv(1, 1, c);
    repeat (3) @(negedge clk);
    chk("R12 held pin", 32'(dlvPin), 32'd6);
    chk("R12 held vector", 32'(dlvVector), 32'h86);
    chk("R12 held request", 32'(dlvReq), 32'd1);
    acceptNow(8'd1);
    expectOffer("R12 lowest next", 1, 8'h81, 8'd1);
    expectOffer("R12 then pin 4", 4, 8'h84, 8'd1);
    expectNone("R12 drained", 6);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

endmodule